// File: doc/BRIEF.md
# Instruction Immediate Sign Extender

This block sits in the datapath of a 16-bit processor. It looks at the instruction word, works out from the opcode and the addressing-mode bits which immediate or offset field the instruction carries, and widens that field to a full 16-bit value. The adder that builds an address or an operand then consumes that value. The block also raises a flag when the instruction has an immediate at all. When there is no immediate, the value is forced to zero.

Five field widths are supported: 5, 6, 8, 9 and 11 bits. The trap vector is zero-extended, so that trap table addresses stay in the lowest memory page. Every other field is sign-extended. Decode is purely combinational. A parameter selects whether the result is registered on the clock. By default it is registered, which gives one cycle of latency.

Top module: `imm_extender`

## Requirements
- R1: While `rst_n` is low, `ext_o` is 0 and `valid_o` is 0.
- R2: For opcode (bits 15:12) 0001 or 0101 with bit 5 at 1, `ext_o` is bits 4:0 sign-extended (bit 4 copied into bits 15:5), and `valid_o` is 1.
- R3: For opcode 0001 or 0101 with bit 5 at 0, `ext_o` is 0 and `valid_o` is 0, whatever bits 4:0 hold.
- R4: For opcode 0110 or 0111, `ext_o` is bits 5:0 sign-extended (bit 5 copied upward), and `valid_o` is 1. Bits 11:6 have no effect.
- R5: For opcodes 0000, 0010, 0011, 1010, 1011 and 1110, `ext_o` is bits 8:0 sign-extended (bit 8 copied upward), and `valid_o` is 1.
- R6: For opcode 0100 with bit 11 at 1, `ext_o` is bits 10:0 sign-extended (bit 10 copied upward), and `valid_o` is 1. With bit 11 at 0, `ext_o` is 0 and `valid_o` is 0.
- R7: For opcode 1111, `ext_o` is bits 7:0 with bits 15:8 at 0, and `valid_o` is 1. Bits 11:8 of the instruction have no effect.
- R8: For opcodes 1000, 1001, 1100 and 1101, `ext_o` is 0 and `valid_o` is 0.
- R9: With the default `REG_OUT`=1, the result for an instruction presented before a rising clock edge appears after that edge. A new instruction can be presented every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset, clears the outputs |
| instr_i | input | 16 | Instruction word |
| ext_o | output | 16 | Extended immediate or offset |
| valid_o | output | 1 | High when the instruction carries an immediate |

## Verification
Each field width is driven with its most negative, its most positive and a mixed pattern. This separates sign extension from zero extension, and it also catches a field taken one bit too wide or too narrow. Bits that lie just above each field are set high, so that a mask which is too wide shows up at the output. The mode bits (bit 5 for the arithmetic ops, bit 11 for the call) are flipped against otherwise identical words, which proves that the mode gates the valid flag. A back-to-back stream of mixed opcodes checks that the output register returns each result exactly one cycle after its instruction.

// File: rtl/imm_extender.sv
module imm_extender #(
  parameter int  DW      = 16,
  parameter bit  REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] instr_i,
  output logic [DW-1:0] ext_o,
  output logic          valid_o
);
  localparam int OPW = 4;

  logic [OPW-1:0] op;
  logic [DW-1:0]  ext_c;
  logic           vld_c;

  assign op = instr_i[DW-1 -: OPW];

  always_comb begin
    ext_c = '0;
    vld_c = 1'b0;
    unique case (op)
      4'b0001, 4'b0101: if (instr_i[5]) begin
        ext_c = {{(DW-5){instr_i[4]}}, instr_i[4:0]};
        vld_c = 1'b1;
      end
      4'b0110, 4'b0111: begin
        ext_c = {{(DW-6){instr_i[5]}}, instr_i[5:0]};
        vld_c = 1'b1;
      end
      4'b0000, 4'b0010, 4'b0011, 4'b1010, 4'b1011, 4'b1110: begin
        ext_c = {{(DW-9){instr_i[8]}}, instr_i[8:0]};
        vld_c = 1'b1;
      end
      4'b0100: if (instr_i[11]) begin
        ext_c = {{(DW-11){instr_i[10]}}, instr_i[10:0]};
        vld_c = 1'b1;
      end
      4'b1111: begin
        ext_c = {{(DW-8){1'b0}}, instr_i[7:0]};
        vld_c = 1'b1;
      end
      default: begin
        ext_c = '0;
        vld_c = 1'b0;
      end
    endcase
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ext_o   <= '0;
          valid_o <= 1'b0;
        end else begin
          ext_o   <= ext_c;
          valid_o <= vld_c;
        end
      end
    end else begin : g_comb
      assign ext_o   = rst_n ? ext_c : '0;
      assign valid_o = rst_n & vld_c;
    end
  endgenerate
endmodule

// File: rtl/imm_extender_chk.sv
module imm_extender_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] instr_i,
  input logic [15:0] ext_o,
  input logic        valid_o
);
  logic primed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;

  always @(posedge clk)
    if (!rst_n) a_r1_reset_zero: assert (ext_o == 16'h0 && !valid_o);

  a_r2_imm5_ext: assert property (@(posedge clk) disable iff (!rst_n)
    primed && ($past(instr_i[15:12]) == 4'h1 || $past(instr_i[15:12]) == 4'h5) && $past(instr_i[5])
    |-> valid_o && ext_o == {{11{$past(instr_i[4])}}, $past(instr_i[4:0])});

  a_r3_reg_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    primed && ($past(instr_i[15:12]) == 4'h1 || $past(instr_i[15:12]) == 4'h5) && !$past(instr_i[5])
    |-> !valid_o && ext_o == 16'h0);

  a_r6_jsrr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(instr_i[15:12]) == 4'h4 && !$past(instr_i[11])
    |-> !valid_o && ext_o == 16'h0);

  a_r7_trap_low_page: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(instr_i[15:12]) == 4'hF
    |-> valid_o && ext_o == {8'h00, $past(instr_i[7:0])});

  a_r8_no_imm: assert property (@(posedge clk) disable iff (!rst_n)
    primed && ($past(instr_i[15:12]) == 4'h8 || $past(instr_i[15:12]) == 4'h9 ||
               $past(instr_i[15:12]) == 4'hC || $past(instr_i[15:12]) == 4'hD)
    |-> !valid_o && ext_o == 16'h0);

  a_r8_invalid_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ext_o == 16'h0);
endmodule

bind imm_extender imm_extender_chk u_chk (
  .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .ext_o(ext_o), .valid_o(valid_o));

// File: tb/imm_extender_tb.sv
module imm_extender_tb;
  typedef struct {
    logic [15:0] ins;
    logic [15:0] ext;
    logic        vld;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr_i = 16'h0;
  logic [15:0] ext_o;
  logic        valid_o;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;
  item_t       q[$];

  always #2 clk = ~clk;

  imm_extender u_dut (.clk(clk), .rst_n(rst_n), .instr_i(instr_i), .ext_o(ext_o), .valid_o(valid_o));

  task automatic send(input logic [15:0] ins, input logic [15:0] ext, input logic vld, input string req);
    item_t it;
    @(negedge clk);
    instr_i = ins;
    it.ins = ins; it.ext = ext; it.vld = vld; it.req = req;
    q.push_back(it);
  endtask

  always begin
    @(posedge clk);
    #1;
    if (rst_n && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (ext_o !== it.ext || valid_o !== it.vld) begin
        errors++;
        $display("FAIL %s instr=%h ext=%h/valid=%b expected %h/%b",
                 it.req, it.ins, ext_o, valid_o, it.ext, it.vld);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    instr_i = 16'h103F;
    @(negedge clk);
    checks++;
    if (ext_o !== 16'h0 || valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 ext=%h/valid=%b expected 0000/0", ext_o, valid_o);
    end
    rst_n = 1'b1;
    send(16'h103F, 16'hFFFF, 1'b1, "R2");
    send(16'h102F, 16'h000F, 1'b1, "R2");
    send(16'h5030, 16'hFFF0, 1'b1, "R2");
    send(16'h1005, 16'h0000, 1'b0, "R3");
    send(16'h501F, 16'h0000, 1'b0, "R3");
    send(16'h6020, 16'hFFE0, 1'b1, "R4");
    send(16'h701F, 16'h001F, 1'b1, "R4");
    send(16'h6FE1, 16'hFFE1, 1'b1, "R4");
    send(16'h0100, 16'hFF00, 1'b1, "R5");
    send(16'h20FF, 16'h00FF, 1'b1, "R5");
    send(16'hA1FF, 16'hFFFF, 1'b1, "R5");
    send(16'hEE01, 16'h0001, 1'b1, "R5");
    send(16'h3155, 16'hFF55, 1'b1, "R5");
    send(16'hB0AA, 16'h00AA, 1'b1, "R5");
    send(16'h4C00, 16'hFC00, 1'b1, "R6");
    send(16'h4BFF, 16'h03FF, 1'b1, "R6");
    send(16'h4400, 16'h0000, 1'b0, "R6");
    send(16'hF0FF, 16'h00FF, 1'b1, "R7");
    send(16'hFF80, 16'h0080, 1'b1, "R7");
    send(16'hF025, 16'h0025, 1'b1, "R7");
    send(16'h9FFF, 16'h0000, 1'b0, "R8");
    send(16'hC1C0, 16'h0000, 1'b0, "R8");
    send(16'h8000, 16'h0000, 1'b0, "R8");
    send(16'hDFFF, 16'h0000, 1'b0, "R8");
    for (int i = 0; i < 8; i++) begin
      send(16'h1020 | 16'(i), 16'(i), 1'b1, "R9");
      send(16'h9000, 16'h0000, 1'b0, "R9");
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule